// File: doc/BRIEF.md
# Microprogrammed Dual-Address Sequencer

This block is the control unit of a small accumulator machine with four instructions. It is built as a microprogram. A 5-bit control address register selects one word of an internal control store. That word drives the 18 datapath enables directly. It also carries two candidate next addresses, one for continuing in sequence and one for a taken jump, together with five condition flags. The next address is picked by a two-way multiplexer. Its select line is true when the word's unconditional flag is set, or when one of the word's four opcode-test flags is set and the decoded instruction matches that flag.

A pass through the machine cycle runs as follows. Three words fetch the instruction. A dispatch chain of four words then tests the opcode, one candidate per word, in this order: load, store, add, jump. The matching routine follows, and its last word jumps back to the first fetch word. Because each word carries its own jump conditions, sequencing needs no decoder on the address register and no step counter. The only decoding is a 2-to-4 decode of the two opcode bits of the instruction register.

Top module: `microseq_top`

## Requirements
- R1: `enables` bit map: 0 memory access, 1 address reg from program counter, 2 program counter from adder, 3 buffer reg from memory, 4 adder operand from buffer, 5 adder operand from accumulator, 6 accumulator from adder, 7 accumulator from buffer, 8 buffer from accumulator, 9 memory from buffer, 10 program counter from instruction address, 11 adder operand from program counter, 12 instruction reg from buffer, 13 address reg from instruction address, 14 carry-in, 15 add, 16 memory read, 17 memory write. While `rstN` is low (asynchronous, active low) the address register holds word 1, so only bit 1 is asserted.
- R2: Fetch is three words, one per clock. Word 1 asserts bit 1. Word 2 asserts bits 0, 3, 11, 14, 15 and 16. Word 3 asserts bits 2 and 12, then jumps to dispatch.
- R3: Opcode encoding on `irOp`: 00 load, 11 store, 01 add, 10 jump. Dispatch tests load, store, add and jump in that order, one word per test, and asserts no enables. A load therefore spends 1 dispatch cycle, a store 2, an add 3 and a jump 4.
- R4: The load routine is three words: bit 13; then bits 0, 3 and 16; then bit 7.
- R5: The store routine is two words: bits 8 and 13; then bits 0, 9 and 17.
- R6: The add routine is four words: bit 13; then bits 0, 3 and 16; then bits 4, 5 and 15; then bit 6.
- R7: The jump routine is one word asserting bit 10.
- R8: After the last word of any routine, the next cycle is fetch word 1.
- R9: `irOp` has no effect outside the dispatch words. Changing it during a routine leaves the rest of that routine unchanged.
- R10: Memory read and memory write are never asserted together, and at most one accumulator source (bit 6 or bit 7) is asserted in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the address register advances on every rising edge |
| rstN | input | 1 | Asynchronous active-low reset to control word 1 |
| irOp | input | 2 | Opcode bits of the instruction register |
| enables | output | 18 | Datapath enables of the current control word (bit map in R1) |

## Verification
The bench drives each opcode through a full cycle and compares every clock's enable vector with a scoreboard. This catches a dispatch chain tested in the wrong order or with the wrong opcode encoding, which would show up as a wrong dispatch length or the wrong routine. A routine end that falls through instead of jumping back would show up as stray enables after the last word. The bench flips the opcode in the middle of a routine; a select term that consulted the opcode outside dispatch would then branch away. A reset in the middle of dispatch must land on fetch word 1 at once, and a synchronous reset or a wrong reset address would fail that check.

// File: rtl/microseq_pkg.sv
package microseq_pkg;

  localparam int CAR_W     = 5;
  localparam int OP_W      = 2;
  localparam int EN_W      = 18;
  localparam logic [CAR_W-1:0] RESET_ADDR = CAR_W'(1);

  // opcode encodings
  localparam logic [OP_W-1:0] OP_LOAD  = 2'b00;
  localparam logic [OP_W-1:0] OP_ADD   = 2'b01;
  localparam logic [OP_W-1:0] OP_JUMP  = 2'b10;
  localparam logic [OP_W-1:0] OP_STORE = 2'b11;

  // datapath strobes, MSB first (memWrite = bit 17, memAccess = bit 0)
  typedef struct packed {
    logic memWrite;
    logic memRead;
    logic aluAdd;
    logic carryIn;
    logic marFromIr;
    logic irFromMbr;
    logic aluSelPc;
    logic pcFromIr;
    logic memFromMbr;
    logic mbrFromAc;
    logic acFromMbr;
    logic acFromAlu;
    logic aluSelAc;
    logic aluSelMbr;
    logic mbrFromMem;
    logic pcFromAlu;
    logic marFromPc;
    logic memAccess;
  } strobes_t;

  typedef struct packed {
    strobes_t           stb;
    logic               kAlways;
    logic               tLoad;
    logic               tStore;
    logic               tAdd;
    logic               tJump;
    logic [CAR_W-1:0]   seqAddr;
    logic [CAR_W-1:0]   jmpAddr;
  } ctlWord_t;

endpackage

// File: rtl/microseq_store.sv
module microseq_store
  import microseq_pkg::*;
#(
  parameter int ADDR_W = CAR_W
) (
  input  logic [ADDR_W-1:0] car,
  output ctlWord_t          word
);

  localparam logic [ADDR_W-1:0] HOME = ADDR_W'(RESET_ADDR);

  always_comb begin
    word         = '0;
    word.seqAddr = HOME;
    word.jmpAddr = HOME;
    case (car)
      // fetch
      ADDR_W'(1): begin
        word.stb.marFromPc = 1'b1;
        word.seqAddr = ADDR_W'(2);
      end
      ADDR_W'(2): begin
        word.stb.memAccess  = 1'b1;
        word.stb.mbrFromMem = 1'b1;
        word.stb.aluSelPc   = 1'b1;
        word.stb.aluAdd     = 1'b1;
        word.stb.carryIn    = 1'b1;
        word.stb.memRead    = 1'b1;
        word.seqAddr = ADDR_W'(3);
      end
      ADDR_W'(3): begin
        word.stb.pcFromAlu = 1'b1;
        word.stb.irFromMbr = 1'b1;
        word.kAlways = 1'b1;
        word.jmpAddr = ADDR_W'(7);
      end
      // load routine
      ADDR_W'(4): begin
        word.stb.marFromIr = 1'b1;
        word.seqAddr = ADDR_W'(5);
      end
      ADDR_W'(5): begin
        word.stb.memAccess  = 1'b1;
        word.stb.mbrFromMem = 1'b1;
        word.stb.memRead    = 1'b1;
        word.seqAddr = ADDR_W'(6);
      end
      ADDR_W'(6): begin
        word.stb.acFromMbr = 1'b1;
        word.kAlways = 1'b1;
      end
      // dispatch chain
      ADDR_W'(7): begin
        word.tLoad = 1'b1;
        word.seqAddr = ADDR_W'(8);
        word.jmpAddr = ADDR_W'(4);
      end
      ADDR_W'(8): begin
        word.tStore = 1'b1;
        word.seqAddr = ADDR_W'(9);
        word.jmpAddr = ADDR_W'(11);
      end
      ADDR_W'(9): begin
        word.tAdd = 1'b1;
        word.seqAddr = ADDR_W'(10);
        word.jmpAddr = ADDR_W'(13);
      end
      ADDR_W'(10): begin
        word.tJump = 1'b1;
        word.seqAddr = ADDR_W'(7);
        word.jmpAddr = ADDR_W'(17);
      end
      // store routine
      ADDR_W'(11): begin
        word.stb.mbrFromAc = 1'b1;
        word.stb.marFromIr = 1'b1;
        word.seqAddr = ADDR_W'(12);
      end
      ADDR_W'(12): begin
        word.stb.memAccess  = 1'b1;
        word.stb.memFromMbr = 1'b1;
        word.stb.memWrite   = 1'b1;
        word.kAlways = 1'b1;
      end
      // add routine
      ADDR_W'(13): begin
        word.stb.marFromIr = 1'b1;
        word.seqAddr = ADDR_W'(14);
      end
      ADDR_W'(14): begin
        word.stb.memAccess  = 1'b1;
        word.stb.mbrFromMem = 1'b1;
        word.stb.memRead    = 1'b1;
        word.seqAddr = ADDR_W'(15);
      end
      ADDR_W'(15): begin
        word.stb.aluSelMbr = 1'b1;
        word.stb.aluSelAc  = 1'b1;
        word.stb.aluAdd    = 1'b1;
        word.seqAddr = ADDR_W'(16);
      end
      ADDR_W'(16): begin
        word.stb.acFromAlu = 1'b1;
        word.kAlways = 1'b1;
      end
      // jump routine
      ADDR_W'(17): begin
        word.stb.pcFromIr = 1'b1;
        word.kAlways = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/microseq_next.sv
module microseq_next
  import microseq_pkg::*;
#(
  parameter int ADDR_W = CAR_W,
  parameter int OPW    = OP_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [OPW-1:0]    irOp,
  input  ctlWord_t          word,
  output logic [ADDR_W-1:0] car
);

  localparam int NUM_OPS = 1 << OPW;

  logic [NUM_OPS-1:0] opHot;
  logic               isLoad, isStore, isAdd, isJump;
  logic               takeJump;
  logic [ADDR_W-1:0]  carNext;

  // 2-to-4 opcode decode
  for (genvar g = 0; g < NUM_OPS; g++) begin : g_dec
    assign opHot[g] = (irOp == OPW'(g));
  end

  assign isLoad  = opHot[OP_LOAD];
  assign isStore = opHot[OP_STORE];
  assign isAdd   = opHot[OP_ADD];
  assign isJump  = opHot[OP_JUMP];

  assign takeJump = word.kAlways
                  | (word.tLoad  & isLoad)
                  | (word.tStore & isStore)
                  | (word.tAdd   & isAdd)
                  | (word.tJump  & isJump);

  assign carNext = takeJump ? word.jmpAddr : word.seqAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) car <= ADDR_W'(RESET_ADDR);
    else       car <= carNext;
  end

endmodule

// File: rtl/microseq_top.sv
module microseq_top
  import microseq_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [OP_W-1:0] irOp,
  output logic [EN_W-1:0] enables
);

  logic [CAR_W-1:0] carQ;
  ctlWord_t         curWord;

  microseq_store #(.ADDR_W(CAR_W)) store_i (
    .car  (carQ),
    .word (curWord)
  );

  microseq_next #(.ADDR_W(CAR_W), .OPW(OP_W)) next_i (
    .clk  (clk),
    .rstN (rstN),
    .irOp (irOp),
    .word (curWord),
    .car  (carQ)
  );

  assign enables = curWord.stb;

endmodule

// File: rtl/microseq_chk.sv
module microseq_chk (
  input logic        clk,
  input logic        rstN,
  input logic [1:0]  irOp,
  input logic [17:0] enables,
  input logic [4:0]  car
);

  AST_FETCH_TO_DISPATCH: assert property (@(posedge clk) disable iff (!rstN)
    car == 5'd3 |=> car == 5'd7); // R2

  AST_DISPATCH_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (car == 5'd7 && irOp == 2'b00) |=> car == 5'd4); // R3

  AST_DISPATCH_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    (car == 5'd7 && irOp != 2'b00) |=> car == 5'd8); // R3

  AST_ROUTINE_RETURN: assert property (@(posedge clk) disable iff (!rstN)
    (car == 5'd6 || car == 5'd12 || car == 5'd16 || car == 5'd17) |=> car == 5'd1); // R8

  AST_DISPATCH_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (car >= 5'd7 && car <= 5'd10) |-> enables == 18'd0); // R3

  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    car >= 5'd1 && car <= 5'd17); // R8

  AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(enables[16] && enables[17])); // R10

  AST_AC_ONE_SRC: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(enables[7:6])); // R10

endmodule

bind microseq_top microseq_chk chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .irOp    (irOp),
  .enables (enables),
  .car     (carQ)
);

// File: tb/microseq_tb_top.sv
module microseq_tb_top;

  localparam int CLK_PERIOD = 10;

  // enable bit positions (R1)
  localparam int B_MEM = 0, B_MARPC = 1, B_PCALU = 2, B_MBRMEM = 3, B_ALUMBR = 4,
                 B_ALUAC = 5, B_ACALU = 6, B_ACMBR = 7, B_MBRAC = 8, B_MEMMBR = 9,
                 B_PCIR = 10, B_ALUPC = 11, B_IRMBR = 12, B_MARIR = 13, B_CIN = 14,
                 B_ADD = 15, B_RD = 16, B_WR = 17;

  localparam logic [17:0] E_F1  = 18'(1) << B_MARPC;
  localparam logic [17:0] E_F2  = (18'(1) << B_MEM) | (18'(1) << B_MBRMEM) | (18'(1) << B_ALUPC)
                                | (18'(1) << B_CIN) | (18'(1) << B_ADD) | (18'(1) << B_RD);
  localparam logic [17:0] E_F3  = (18'(1) << B_PCALU) | (18'(1) << B_IRMBR);
  localparam logic [17:0] E_MIR = 18'(1) << B_MARIR;
  localparam logic [17:0] E_RDM = (18'(1) << B_MEM) | (18'(1) << B_MBRMEM) | (18'(1) << B_RD);
  localparam logic [17:0] E_L3  = 18'(1) << B_ACMBR;
  localparam logic [17:0] E_S1  = (18'(1) << B_MBRAC) | (18'(1) << B_MARIR);
  localparam logic [17:0] E_S2  = (18'(1) << B_MEM) | (18'(1) << B_MEMMBR) | (18'(1) << B_WR);
  localparam logic [17:0] E_A3  = (18'(1) << B_ALUMBR) | (18'(1) << B_ALUAC) | (18'(1) << B_ADD);
  localparam logic [17:0] E_A4  = 18'(1) << B_ACALU;
  localparam logic [17:0] E_J1  = 18'(1) << B_PCIR;

  localparam logic [1:0] OPL = 2'b00, OPS = 2'b11, OPA = 2'b01, OPJ = 2'b10;

  typedef struct {
    logic [17:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  irOp = 2'b00;
  logic [17:0] enables;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  item_t expQ[$];

  microseq_top dut_i (
    .clk     (clk),
    .rstN    (rstN),
    .irOp    (irOp),
    .enables (enables)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic [17:0] act, input logic [17:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: enables actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push(input logic [17:0] e, input string tag);
    item_t it;
    it.exp = e;
    it.tag = tag;
    expQ.push_back(it);
  endtask

  // monitor: compare one expected item per clock, sampled mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        item_t it;
        it = expQ.pop_front();
        check(enables, it.exp, it.tag);
      end
    end
  end

  // driver: one full instruction pass, called just after a rising edge with the CAR at word 1
  task automatic runInstr(input logic [1:0] op, input bit flip, input bit afterRet);
    int dispLen;
    int total;
    string rt;
    irOp = op;
    push(E_F1, afterRet ? "R8" : "R2");
    push(E_F2, "R2");
    push(E_F3, "R2");
    case (op)
      OPL: dispLen = 1;
      OPS: dispLen = 2;
      OPA: dispLen = 3;
      default: dispLen = 4;
    endcase
    for (int i = 0; i < dispLen; i++) push(18'd0, "R3");
    rt = flip ? "R9" : "";
    case (op)
      OPL: begin
        push(E_MIR, flip ? rt : "R4"); push(E_RDM, flip ? rt : "R4"); push(E_L3, flip ? rt : "R4");
        total = 3 + dispLen + 3;
      end
      OPS: begin
        push(E_S1, flip ? rt : "R5"); push(E_S2, flip ? rt : "R5");
        total = 3 + dispLen + 2;
      end
      OPA: begin
        push(E_MIR, flip ? rt : "R6"); push(E_RDM, flip ? rt : "R6");
        push(E_A3, flip ? rt : "R6");  push(E_A4, flip ? rt : "R6");
        total = 3 + dispLen + 4;
      end
      default: begin
        push(E_J1, flip ? rt : "R7");
        total = 3 + dispLen + 1;
      end
    endcase
    for (int c = 0; c < total; c++) begin
      @(posedge clk);
      if (flip && c == 3 + dispLen - 1) begin
        #1 irOp = ~op;
      end
    end
    #1;
  endtask

  initial begin
    // R1: reset state
    @(negedge clk);
    check(enables, E_F1, "R1");
    @(posedge clk);
    #1 rstN = 1'b1;

    runInstr(OPL, 1'b0, 1'b0);
    runInstr(OPS, 1'b0, 1'b1);
    runInstr(OPA, 1'b0, 1'b1);
    runInstr(OPJ, 1'b0, 1'b1);
    runInstr(OPA, 1'b0, 1'b1);
    runInstr(OPL, 1'b1, 1'b1);
    runInstr(OPS, 1'b1, 1'b1);
    runInstr(OPA, 1'b1, 1'b1);
    runInstr(OPJ, 1'b0, 1'b1);

    // R1: asynchronous reset during dispatch returns to word 1 at once
    irOp = OPJ;
    repeat (5) @(posedge clk);
    #1 rstN = 1'b0;
    #1 check(enables, E_F1, "R1");
    @(negedge clk);
    check(enables, E_F1, "R1");
    @(posedge clk);
    #1 rstN = 1'b1;
    runInstr(OPS, 1'b0, 1'b0);
    runInstr(OPL, 1'b0, 1'b1);

    @(negedge clk);
    check(18'(expQ.size()), 18'd0, "R8");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // watchdog
  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion (R8)");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule